// File: doc/BRIEF.md
# Serial NOR Range Erase Sequencer

This block erases a byte range of a serial NOR flash on its own, over a single-lane SPI link in mode 0. The requester gives a start offset and a length, together with the device geometry: the total size, the size of one erase unit, and a flag that says whether the device accepts uniform 4 KiB erases. The block issues one start pulse. It then drives the flash through its internal bit serializer and reports the outcome with a one-cycle completion pulse and two result flags.

Each erase is guarded in the same way. First, status-read frames repeat until the flash reports that it is idle. Next comes a single write-enable frame, and then the erase frame itself. A request whose length equals the whole device becomes a single chip-erase frame. Any other request becomes a walk over the range, one erase unit at a time.

The status wait is bounded. Its limit is a number of seconds multiplied by the clock frequency, and both are parameters, so a bench can shrink the wait to a few thousand cycles.

Top module: `spi_erase_seq`

## Requirements
- R1: A request with offset + length greater than the device size (computed without overflow) is rejected. The block pulses done with bad_range = 1 and sends no frame.
- R2: Before each erase frame, the block sends status-read frames (opcode 0x05 followed by one read byte). It repeats them while bit 0 of the returned byte is 1, and proceeds once that bit is 0.
- R3: Between the last status-read frame and each erase frame, the block sends exactly one single-byte frame with opcode 0x06.
- R4: When the length equals the device size, the only erase frame is the single byte 0xC7, with no address.
- R5: Otherwise, the block sends one erase frame per unit. The address starts at the offset and grows by the unit size each step. A final partial unit is still erased.
- R6: The unit erase opcode is 0x20 when the uniform-4KiB flag is 1, and 0xD8 when it is 0.
- R7: The address follows the opcode, most significant byte first. It is 3 bytes long, or 4 bytes when the device size is greater than 2^24 bytes.
- R8: If a status read still shows bit 0 set after CLK_HZ*WAIT_S cycles of polling, the block pulses done with timeout = 1. It sends no write-enable or erase frame after that point.
- R9: Chip select is low for a whole frame and high for at least one cycle between frames. SCK idles low. Bits are sent MSB first, set up while SCK is low and sampled on its rising edge.
- R10: busy is high from an accepted start until done. done is a one-cycle pulse. The result flags hold until the next accepted start. A zero length completes with no frame. start is ignored while busy or during the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| offset | input | ADDR_W | First byte to erase |
| length | input | ADDR_W | Number of bytes to erase |
| dev_size | input | ADDR_W | Device size in bytes |
| unit_size | input | ADDR_W | Erase unit size in bytes |
| small_unit | input | 1 | Device accepts uniform 4 KiB erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| bad_range | output | 1 | Last request rejected |
| timeout | output | 1 | Last request abandoned on status wait |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
Most internal faults in this block show at the pins within one frame, as a wrong byte stream. A wrong step or remaining-length register shows as an erase address that is off, or as one unit too many or too few, by the second erase frame at the latest. A wrong opcode choice or address-width decision corrupts the very first erase frame. A broken poll or write-enable ordering puts the frames in the wrong sequence. A broken timer is different: it shows only as a timeout flag that comes too early or never comes, so the bench brackets the completion time of a request that never clears its busy bit.

// File: rtl/erase_pkg.sv
package erase_pkg;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_CHIP   = 8'hC7;
  localparam logic [7:0] OP_SMALL  = 8'h20;
  localparam logic [7:0] OP_LARGE  = 8'hD8;
  localparam logic [7:0] WIP_MASK  = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_POLL_W, ST_WREN, ST_WREN_W, ST_ERASE, ST_ERASE_W
  } seq_state_t;
endpackage

// File: rtl/erase_frame_fmt.sv
module erase_frame_fmt #(
  parameter int ADDR_W = 32,
  parameter int MAXB   = 5
) (
  input  logic [7:0]          op,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                with_addr,
  input  logic                wide,
  output logic [MAXB*8-1:0]   tx,
  output logic [2:0]          ntx
);
  localparam int TXW = MAXB*8;
  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    if (!with_addr) begin
      tx  = {op, {(TXW-8){1'b0}}};
      ntx = 3'd1;
    end else if (wide) begin
      tx  = {op, a32, {(TXW-40){1'b0}}};
      ntx = 3'd5;
    end else begin
      tx  = {op, a32[23:0], {(TXW-32){1'b0}}};
      ntx = 3'd4;
    end
  end
endmodule

// File: rtl/erase_poll_timer.sv
module erase_poll_timer #(
  parameter longint unsigned CLK_HZ = 250_000_000,
  parameter int unsigned     WAIT_S = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam longint unsigned LIMIT = CLK_HZ * WAIT_S;
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && cnt != TW'(LIMIT)) cnt <= cnt + 1'b1;
  end
  assign expired = (cnt == TW'(LIMIT));

  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !expired); // R8
endmodule

// File: rtl/spi_byte_ser.sv
module spi_byte_ser #(
  parameter int MAXB = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [MAXB*8-1:0] tx,
  input  logic [2:0]        ntx,
  input  logic              rx_en,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rx_byte,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int TXW = MAXB*8;
  localparam int CW  = $clog2(TXW + 9);
  logic [TXW-1:0] sh;
  logic [CW-1:0]  bits;
  logic           ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; cs_n <= 1'b1; sck <= 1'b0; mosi <= 1'b0;
      ph <= 1'b0; bits <= '0; sh <= '0; rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1; cs_n <= 1'b0; sh <= tx; mosi <= tx[TXW-1]; ph <= 1'b0;
          bits <= CW'(ntx) * CW'(8) + (rx_en ? CW'(8) : CW'(0));
        end
      end else if (!ph) begin
        sck <= 1'b1; ph <= 1'b1;
      end else begin
        sck <= 1'b0; ph <= 1'b0;
        rx_byte <= {rx_byte[6:0], miso};
        sh <= sh << 1;
        mosi <= sh[TXW-2];
        bits <= bits - 1'b1;
        if (bits == CW'(1)) begin
          busy <= 1'b0; cs_n <= 1'b1; done <= 1'b1; mosi <= 1'b0;
        end
      end
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck); // R9
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy); // R9
endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
  import erase_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter longint unsigned CLK_HZ = 250_000_000,
  parameter int unsigned     WAIT_S = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] length,
  input  logic [ADDR_W-1:0] dev_size,
  input  logic [ADDR_W-1:0] unit_size,
  input  logic              small_unit,
  output logic              busy,
  output logic              done,
  output logic              bad_range,
  output logic              timeout,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int MAXB = 5;
  localparam logic [ADDR_W-1:0] WIDE_ABOVE = ADDR_W'(32'h0100_0000);

  seq_state_t state;
  logic [ADDR_W-1:0] addr_q, left_q, unit_q;
  logic small_q, wide_q, whole_q;
  logic [ADDR_W:0] end_sum;

  logic ser_go, ser_busy, ser_done, tm_exp, with_addr, rx_en;
  logic [7:0] ser_rx, op_sel;
  logic [MAXB*8-1:0] tx;
  logic [2:0] ntx;

  assign end_sum = {1'b0, offset} + {1'b0, length};

  always_comb begin
    ser_go = 1'b0; rx_en = 1'b0; with_addr = 1'b0; op_sel = OP_STATUS;
    unique case (state)
      ST_POLL:  begin ser_go = 1'b1; rx_en = 1'b1; end
      ST_WREN:  begin ser_go = 1'b1; op_sel = OP_WREN; end
      ST_ERASE: begin
        ser_go = 1'b1;
        if (whole_q) op_sel = OP_CHIP;
        else begin
          with_addr = 1'b1;
          op_sel = small_q ? OP_SMALL : OP_LARGE;
        end
      end
      default: ;
    endcase
  end

  erase_frame_fmt #(.ADDR_W(ADDR_W), .MAXB(MAXB)) u_fmt (
    .op(op_sel), .addr(addr_q), .with_addr(with_addr), .wide(wide_q),
    .tx(tx), .ntx(ntx));

  erase_poll_timer #(.CLK_HZ(CLK_HZ), .WAIT_S(WAIT_S)) u_timer (
    .clk(clk), .rst(rst),
    .clr(state != ST_POLL && state != ST_POLL_W),
    .run(state == ST_POLL || state == ST_POLL_W),
    .expired(tm_exp));

  spi_byte_ser #(.MAXB(MAXB)) u_ser (
    .clk(clk), .rst(rst), .go(ser_go), .tx(tx), .ntx(ntx), .rx_en(rx_en),
    .busy(ser_busy), .done(ser_done), .rx_byte(ser_rx),
    .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; busy <= 1'b0; done <= 1'b0; bad_range <= 1'b0;
      timeout <= 1'b0; addr_q <= '0; left_q <= '0; unit_q <= '0;
      small_q <= 1'b0; wide_q <= 1'b0; whole_q <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start && !done) begin
          bad_range <= 1'b0; timeout <= 1'b0;
          if (end_sum > {1'b0, dev_size}) begin
            bad_range <= 1'b1; done <= 1'b1;
          end else if (length == '0) begin
            done <= 1'b1;
          end else begin
            busy <= 1'b1; state <= ST_POLL;
            addr_q <= offset; left_q <= length; unit_q <= unit_size;
            small_q <= small_unit; wide_q <= (dev_size > WIDE_ABOVE);
            whole_q <= (length == dev_size);
          end
        end
        ST_POLL:  state <= ST_POLL_W;
        ST_POLL_W: if (ser_done) begin
          if ((ser_rx & WIP_MASK) == 8'h00) state <= ST_WREN;
          else if (tm_exp) begin
            timeout <= 1'b1; done <= 1'b1; busy <= 1'b0; state <= ST_IDLE;
          end else state <= ST_POLL;
        end
        ST_WREN:   state <= ST_WREN_W;
        ST_WREN_W: if (ser_done) state <= ST_ERASE;
        ST_ERASE:  state <= ST_ERASE_W;
        ST_ERASE_W: if (ser_done) begin
          if (whole_q || left_q <= unit_q) begin
            done <= 1'b1; busy <= 1'b0; state <= ST_IDLE;
          end else begin
            addr_q <= addr_q + unit_q; left_q <= left_q - unit_q;
            state <= ST_POLL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bad_range && !busy) |-> spi_cs_n); // R1
  AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (timeout && !busy) |-> (spi_cs_n && !ser_busy)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
endmodule

// File: tb/spi_erase_seq_test.sv
module spi_erase_seq_test;
  localparam int AW = 32;
  localparam longint unsigned HZ = 100;
  localparam int unsigned WS = 40;
  localparam int LIMIT = 4000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, small_unit = 1'b0;
  logic [AW-1:0] offset = '0, length = '0, dev_size = '0, unit_size = '0;
  logic busy, done, bad_range, timeout, cs_n, sck, mosi;
  logic miso = 1'b0;

  always #2 clk = ~clk;

  spi_erase_seq #(.ADDR_W(AW), .CLK_HZ(HZ), .WAIT_S(WS)) uut (
    .clk(clk), .rst(rst), .start(start), .offset(offset), .length(length),
    .dev_size(dev_size), .unit_size(unit_size), .small_unit(small_unit),
    .busy(busy), .done(done), .bad_range(bad_range), .timeout(timeout),
    .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso));

  typedef struct { int nb; logic [47:0] v; string tag; } item_t;
  item_t q[$];
  int vectors = 0, fails = 0, busy_left = 0, sck_bad = 0;
  bit loose = 1'b0;
  logic [47:0] fdata = '0;
  int fbits = 0;
  logic [7:0] stat = 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // flash model and monitor
  always @(negedge cs_n) begin
    fbits = 0; fdata = '0;
    stat = (busy_left > 0) ? 8'h01 : 8'h00;
  end
  always @(posedge sck) if (cs_n === 1'b0) begin
    fdata = {fdata[46:0], mosi}; fbits++;
  end
  always @(negedge sck) if (cs_n === 1'b0 && fbits >= 8 && fbits < 16)
    miso = stat[15-fbits];
  always @(posedge cs_n) if (fbits > 0) begin
    automatic int nb = fbits / 8;
    automatic logic [7:0] first = 8'(fdata >> ((nb-1)*8));
    if (first == 8'h05 && busy_left > 0) busy_left--;
    if (fbits % 8 != 0) chk(1'b0, "R9 whole bytes", 48'(fbits), 48'(nb*8));
    else if (loose) chk(nb == 2 && fdata == 48'h0500, "R8 only status reads", fdata, 48'h0500);
    else if (q.size() == 0) chk(1'b0, "unexpected frame (R1/R10)", fdata, 48'h0);
    else begin
      automatic item_t it = q.pop_front();
      chk(nb == it.nb && fdata == it.v, it.tag, fdata, it.v);
    end
    fbits = 0;
  end
  always @(negedge clk) if (!rst && cs_n && sck) sck_bad++;

  function automatic void push(input int nb, input logic [47:0] v, input string tag);
    item_t it; it.nb = nb; it.v = v; it.tag = tag; q.push_back(it);
  endfunction

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
  endtask

  task automatic run_req(input logic [31:0] off, input logic [31:0] len, input logic [31:0] sz,
                         input logic [31:0] un, input bit sm, input int bpolls,
                         input bit exp_bad, input string tag);
    automatic int cyc;
    busy_left = bpolls;
    if (!exp_bad && len != 0) begin
      if (len == sz) begin
        for (int i = 0; i <= bpolls; i++) push(2, 48'h0500, "R2 status poll");
        push(1, 48'h06, "R3 write enable");
        push(1, 48'hC7, "R4 chip erase");
      end else begin
        automatic logic [31:0] a = off, rem = len;
        automatic bit first = 1'b1;
        while (rem != 0) begin
          for (int i = 0; i <= (first ? bpolls : 0); i++) push(2, 48'h0500, "R2 status poll");
          first = 1'b0;
          push(1, 48'h06, "R3 write enable");
          if (sz > 32'h0100_0000) push(5, {8'h00, (sm ? 8'h20 : 8'hD8), a}, {tag, " R7 4-byte addr"});
          else push(4, {16'h0, (sm ? 8'h20 : 8'hD8), a[23:0]}, {tag, " R5/R6 unit erase"});
          a = a + un;
          rem = (rem > un) ? rem - un : 0;
        end
      end
    end
    offset = off; length = len; dev_size = sz; unit_size = un; small_unit = sm;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(cyc);
    chk(done === 1'b1, {tag, " R10 done"}, 48'(done), 48'h1);
    @(negedge clk);
    chk(bad_range === exp_bad && timeout === 1'b0, {tag, " R1 flags"}, {bad_range, timeout}, {exp_bad, 1'b0});
    chk(busy === 1'b0 && done === 1'b0, {tag, " R10 pulse"}, {busy, done}, 48'h0);
    repeat (4) @(negedge clk);
    chk(q.size() == 0 && bad_range === exp_bad, {tag, " all frames seen, flag held"}, 48'(q.size()), 48'h0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    automatic int cyc;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0 && done === 1'b0,
        "reset state R9/R10", {cs_n, sck, busy, done}, 48'b1000);

    run_req(32'h1000, 32'h3000, 32'h10_0000, 32'h1000, 1'b1, 0, 1'b0, "R6 small units");
    run_req(32'h1_0000, 32'h2_0000, 32'h10_0000, 32'h1_0000, 1'b0, 2, 1'b0, "R2 busy polls large units");
    run_req(32'h0, 32'h10_0000, 32'h10_0000, 32'h1_0000, 1'b0, 1, 1'b0, "R4 whole chip");
    run_req(32'h1FF_0000, 32'h1_0000, 32'h200_0000, 32'h1_0000, 1'b0, 0, 1'b0, "R7 wide at end");
    run_req(32'h0, 32'h1800, 32'h10_0000, 32'h1000, 1'b1, 0, 1'b0, "R5 partial unit");
    run_req(32'hF_F000, 32'h2000, 32'h10_0000, 32'h1000, 1'b1, 0, 1'b1, "R1 past end");
    run_req(32'hFFFF_F000, 32'h2000, 32'h10_0000, 32'h1000, 1'b1, 0, 1'b1, "R1 wraparound");
    run_req(32'h2000, 32'h0, 32'h10_0000, 32'h1000, 1'b1, 0, 1'b0, "R10 zero length");

    // R8: status never clears
    loose = 1'b1; busy_left = 1000000;
    offset = 32'h0; length = 32'h1000; dev_size = 32'h10_0000; unit_size = 32'h1000; small_unit = 1'b1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(cyc);
    chk(done === 1'b1 && timeout === 1'b1 && bad_range === 1'b0, "R8 timeout flag",
        {done, timeout, bad_range}, 48'b110);
    chk(cyc >= LIMIT && cyc <= LIMIT + 80, "R8 wait length", 48'(cyc), 48'(LIMIT));
    repeat (50) @(negedge clk);
    chk(timeout === 1'b1 && cs_n === 1'b1, "R8 quiet after timeout", {timeout, cs_n}, 48'b11);
    loose = 1'b0; busy_left = 0;

    run_req(32'h4000, 32'h1000, 32'h10_0000, 32'h1000, 1'b1, 0, 1'b0, "R10 flags cleared");
    chk(sck_bad == 0, "R9 sck low while deselected", 48'(sck_bad), 48'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule